// File: doc/BRIEF.md
# Bus Error Capture Unit

This unit sits beside a shared on-chip bus and records what the bus looked like when an access ended in an error response. When capture is enabled and armed, the first error latches the bus control field, the address and the data into three capture registers. Those values then stay frozen. A 16-bit saturating counter keeps counting every further error, so software can later see both what went wrong first and how often errors happened afterwards.

Software reaches the unit through a small register port with a select, a read strobe, a write strobe and 32-bit data. The control/count register is at select 0, the captured address at select 1 and the captured data at select 2. Select 3 reads as zero. Reading the control/count register has a side effect: it re-arms capture, so the next error is recorded afresh. Software can also load the counter with any value through the same register.

Top module: `bus_err_capture`

## Requirements
- R1: While `dbgEn` is 0, a bus error changes neither the counter nor the captured control, address or data.
- R2: When `dbgEn` is 1 and capture is armed, a cycle with `busErr` high latches `busCtrl`, `busAddr` and `busData`. The latched values can be read from the next cycle onward: the address at select 1, the data at select 2, and the control in bits [27:16] of select 0.
- R3: Once an error has been captured, later errors do not change the captured control, address or data until software re-arms capture.
- R4: Each cycle with `dbgEn` high and `busErr` high adds one to the error count in bits [15:0] of select 0. The error that is captured counts too.
- R5: The error count saturates at 65535 and never wraps to zero.
- R6: After reset the count, the captured fields and the register reads are all zero, and capture is armed.
- R7: A write to select 0 loads bits [15:0] of the write data into the error count.
- R8: A read of select 0 re-arms capture from the next cycle, so the next error overwrites the captured control, address and data.
- R9: If a select-0 read and a bus error fall in the same cycle, the count still increments and capture is re-armed, so the following error is captured.
- R10: If a select-0 write and a bus error fall in the same cycle, the written value ends up in the count and the increment is lost.
- R11: Bits [31:28] of select 0 and every bit of select 3 read as zero. Write data in bits [31:16] has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgEn | input | 1 | Enables error capture and counting |
| busErr | input | 1 | Bus error response strobe, one cycle per error |
| busCtrl | input | CTRL_W (12) | Bus control field at the time of the error |
| busAddr | input | ADDR_W (32) | Bus address at the time of the error |
| busData | input | DATA_W (32) | Bus data at the time of the error |
| regSel | input | 2 | Register select: 0 control/count, 1 address, 2 data, 3 zero |
| regRd | input | 1 | Register read strobe (a read of select 0 re-arms capture) |
| regWr | input | 1 | Register write strobe |
| regWdata | input | REG_W (32) | Register write data |
| regRdata | output | REG_W (32) | Register read data, valid in the same cycle as the read |

## Verification
Read data is combinational, so the value belonging to a read is due in the same cycle as `regRd`. The bench samples it on the falling edge of that cycle. A bus error, a count write and the re-arm effect of a read each take effect at the next rising edge, so they only become visible to a read issued in a later cycle. The driver changes inputs just after a rising edge and pushes the expected read value into the queue at that moment. The monitor compares on the falling edge, half a cycle later. This keeps every comparison clear of the edges where the registers update.

// File: rtl/bec_pkg.sv
package bec_pkg;

  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd2;

  // Strobes passed from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic capture;   // latch control, address and data
    logic count;     // one qualified error this cycle
    logic cntWrite;  // software loads the counter
  } becStrobes_t;

endpackage

// File: rtl/bec_sat_counter.sv
module bec_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] qNext;

  always_comb begin
    if (load) begin
      qNext = loadVal;
    end else if (inc && (q != MAX_VAL)) begin
      qNext = q + 1'b1;
    end else begin
      qNext = q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q <= '0;
    end else begin
      q <= qNext;
    end
  end

endmodule

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dbgEn,
  input  logic             busErr,
  input  logic [SEL_W-1:0] regSel,
  input  logic             regRd,
  input  logic             regWr,
  output becStrobes_t      stb,
  output logic             capturedQ
);

  logic errSeen;
  logic ctrlRead;
  logic ctrlWrite;
  logic capturedNext;

  assign errSeen   = dbgEn && busErr;
  assign ctrlRead  = regRd && (regSel == SEL_CTRL);
  assign ctrlWrite = regWr && (regSel == SEL_CTRL);

  always_comb begin
    stb          = '0;
    stb.capture  = errSeen && !capturedQ;
    stb.count    = errSeen;
    stb.cntWrite = ctrlWrite;
  end

  // A read of the control register wins over a capture in the same cycle.
  always_comb begin
    if (ctrlRead) begin
      capturedNext = 1'b0;
    end else begin
      capturedNext = capturedQ || stb.capture;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capturedQ <= 1'b0;
    end else begin
      capturedQ <= capturedNext;
    end
  end

endmodule

// File: rtl/bec_datapath.sv
module bec_datapath
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 12,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  becStrobes_t       stb,
  input  logic [CTRL_W-1:0] busCtrl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [CNT_W-1:0]  wrCount,
  output logic [CTRL_W-1:0] ctlQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] datQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic [REG_W-1:0]  regRdata
);

  localparam int CTRL_LSB = CNT_W;
  localparam int CTRL_MSB = CNT_W + CTRL_W - 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= '0;
      addrQ <= '0;
      datQ  <= '0;
    end else if (stb.capture) begin
      ctlQ  <= busCtrl;
      addrQ <= busAddr;
      datQ  <= busData;
    end
  end

  bec_sat_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rstN    (rstN),
    .inc     (stb.count),
    .load    (stb.cntWrite),
    .loadVal (wrCount),
    .q       (cntQ)
  );

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_CTRL: begin
        regRdata[CNT_W-1:0]         = cntQ;
        regRdata[CTRL_MSB:CTRL_LSB] = ctlQ;
      end
      SEL_ADDR: regRdata[ADDR_W-1:0] = addrQ;
      SEL_DATA: regRdata[DATA_W-1:0] = datQ;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 12,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEn,
  input  logic              busErr,
  input  logic [CTRL_W-1:0] busCtrl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata
);

  becStrobes_t       stb;
  logic              capturedQ;
  logic [CTRL_W-1:0] ctlQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] datQ;
  logic [CNT_W-1:0]  cntQ;
  logic              unusedWrHigh;

  // Upper write-data bits select no register field.
  assign unusedWrHigh = ^regWdata[REG_W-1:CNT_W];

  bec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dbgEn     (dbgEn),
    .busErr    (busErr),
    .regSel    (regSel),
    .regRd     (regRd),
    .regWr     (regWr),
    .stb       (stb),
    .capturedQ (capturedQ)
  );

  bec_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .CNT_W  (CNT_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busCtrl  (busCtrl),
    .busAddr  (busAddr),
    .busData  (busData),
    .regSel   (regSel),
    .wrCount  (regWdata[CNT_W-1:0]),
    .ctlQ     (ctlQ),
    .addrQ    (addrQ),
    .datQ     (datQ),
    .cntQ     (cntQ),
    .regRdata (regRdata)
  );

endmodule

// File: rtl/bec_checker.sv
module bec_checker
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 12,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              dbgEn,
  input logic              busErr,
  input logic [CTRL_W-1:0] busCtrl,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic [SEL_W-1:0]  regSel,
  input logic              regRd,
  input logic              regWr,
  input logic [CNT_W-1:0]  wrCount,
  input logic [REG_W-1:0]  regRdata,
  input logic              capturedQ,
  input logic [CTRL_W-1:0] ctlQ,
  input logic [ADDR_W-1:0] addrQ,
  input logic [DATA_W-1:0] datQ,
  input logic [CNT_W-1:0]  cntQ
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int RSV_LSB = CNT_W + CTRL_W;

  logic ctrlRead;
  logic ctrlWrite;
  assign ctrlRead  = regRd && (regSel == SEL_CTRL);
  assign ctrlWrite = regWr && (regSel == SEL_CTRL);

  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgEn && !ctrlWrite) |=> ($stable(cntQ) && $stable(addrQ) && $stable(datQ) && $stable(ctlQ))); // R1

  AST_FIRST_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEn && busErr && !capturedQ) |=>
      (addrQ == $past(busAddr) && datQ == $past(busData) && ctlQ == $past(busCtrl))); // R2

  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (capturedQ && !ctrlRead) |=> ($stable(addrQ) && $stable(datQ) && $stable(ctlQ))); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEn && busErr && !ctrlWrite && cntQ != CNT_MAX) |=> (cntQ == CNT_W'($past(cntQ) + 1'b1))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CNT_MAX && !ctrlWrite) |=> (cntQ == CNT_MAX)); // R5

  AST_REARM: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRead |=> !capturedQ); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (cntQ == $past(wrCount))); // R10

  always_comb begin
    if (rstN && regSel == SEL_CTRL) begin
      AST_RSV_ZERO: assert (regRdata[REG_W-1:RSV_LSB] == '0); // R11
    end
  end

endmodule

bind bus_err_capture bec_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CTRL_W (CTRL_W),
  .CNT_W  (CNT_W),
  .REG_W  (REG_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dbgEn     (dbgEn),
  .busErr    (busErr),
  .busCtrl   (busCtrl),
  .busAddr   (busAddr),
  .busData   (busData),
  .regSel    (regSel),
  .regRd     (regRd),
  .regWr     (regWr),
  .wrCount   (regWdata[CNT_W-1:0]),
  .regRdata  (regRdata),
  .capturedQ (capturedQ),
  .ctlQ      (ctlQ),
  .addrQ     (addrQ),
  .datQ      (datQ),
  .cntQ      (cntQ)
);

// File: tb/tb_bus_err_capture.sv
module tb_bus_err_capture;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic        dbgEn;
  logic        busErr;
  logic [11:0] busCtrl;
  logic [31:0] busAddr;
  logic [31:0] busData;
  logic [1:0]  regSel;
  logic        regRd;
  logic        regWr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t sb[$];
  expItem_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_err_capture dut (
    .clk      (clk),
    .rstN     (rstN),
    .dbgEn    (dbgEn),
    .busErr   (busErr),
    .busCtrl  (busCtrl),
    .busAddr  (busAddr),
    .busData  (busData),
    .regSel   (regSel),
    .regRd    (regRd),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata)
  );

  // Monitor: read data is due in the cycle of the read strobe.
  always @(negedge clk) begin
    if (rstN === 1'b1 && regRd === 1'b1) begin
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty on read, actual=%h expected=none", regRdata);
      end else begin
        cur = sb.pop_front();
        if (regRdata !== cur.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", cur.tag, regSel, regRdata, cur.exp);
        end
      end
    end
  end

  function automatic logic [31:0] ctlWord(input logic [11:0] c, input logic [15:0] n);
    return {4'h0, c, n};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    busErr = 1'b0;
    regRd  = 1'b0;
    regWr  = 1'b0;
  endtask

  task automatic setErr(input logic [11:0] c, input logic [31:0] a, input logic [31:0] d);
    busErr  = 1'b1;
    busCtrl = c;
    busAddr = a;
    busData = d;
  endtask

  task automatic errPulse(input logic [11:0] c, input logic [31:0] a, input logic [31:0] d);
    setErr(c, a, d);
    tick();
  endtask

  task automatic setRd(input logic [1:0] s, input logic [31:0] e, input string t);
    expItem_t it;
    it.exp = e;
    it.tag = t;
    sb.push_back(it);
    regSel = s;
    regRd  = 1'b1;
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] e, input string t);
    setRd(s, e, t);
    tick();
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    regSel   = s;
    regWr    = 1'b1;
    regWdata = v;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; dbgEn = 1'b0; busErr = 1'b0; busCtrl = '0; busAddr = '0; busData = '0;
    regSel = '0; regRd = 1'b0; regWr = 1'b0; regWdata = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R6: reset state
    rd(2'd0, 32'h0, "R6 ctrl after reset");
    rd(2'd1, 32'h0, "R6 addr after reset");
    rd(2'd2, 32'h0, "R6 data after reset");

    // R1: an error while capture is disabled is ignored
    errPulse(12'hABC, 32'hAAAA_0000, 32'h1111_1111);
    rd(2'd0, 32'h0, "R1 ctrl/count untouched");
    rd(2'd1, 32'h0, "R1 addr untouched");

    // R2 / R3 / R4: the first error is kept, later ones are only counted
    dbgEn = 1'b1;
    errPulse(12'h123, 32'h1000_0004, 32'hDEAD_BEEF);
    rd(2'd1, 32'h1000_0004, "R2 addr captured");
    rd(2'd2, 32'hDEAD_BEEF, "R2 data captured");
    errPulse(12'h456, 32'h0000_2000, 32'h0000_0001);
    rd(2'd1, 32'h1000_0004, "R3 addr kept");
    rd(2'd2, 32'hDEAD_BEEF, "R3 data kept");
    rd(2'd0, ctlWord(12'h123, 16'd2), "R4 count and ctrl");

    // R8: the read above re-armed capture
    errPulse(12'h789, 32'h0000_C000, 32'h0000_00CC);
    rd(2'd1, 32'h0000_C000, "R8 new addr after rearm");

    // R7 / R11: count load, upper write bits ignored; R5 saturation
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, ctlWord(12'h789, 16'hFFFE), "R7 R11 count loaded, upper bits ignored");
    errPulse(12'h0AA, 32'h0000_3000, 32'h0000_0033);
    errPulse(12'h0BB, 32'h0000_3100, 32'h0000_0034);
    rd(2'd0, ctlWord(12'h0AA, 16'hFFFF), "R5 count saturates");

    // R9: read and error in the same cycle
    errPulse(12'h111, 32'h0000_4000, 32'h0000_0044);
    wr(2'd0, 32'h0000_0005);
    setErr(12'h999, 32'h0000_9000, 32'h0000_0099);
    setRd(2'd0, ctlWord(12'h111, 16'd5), "R9 read with error");
    tick();
    errPulse(12'h222, 32'h0000_5000, 32'h0000_0055);
    rd(2'd1, 32'h0000_5000, "R9 next error captured");
    rd(2'd0, ctlWord(12'h222, 16'd7), "R9 count kept incrementing");

    // R10: write and error in the same cycle
    setErr(12'h333, 32'h0000_6000, 32'h0000_0066);
    regSel = 2'd0; regWr = 1'b1; regWdata = 32'h0000_0020;
    tick();
    rd(2'd0, ctlWord(12'h333, 16'h0020), "R10 write wins over increment");

    // R11: unused select reads zero
    rd(2'd3, 32'h0, "R11 select 3 reads zero");

    // R1: disabled while armed
    dbgEn = 1'b0;
    errPulse(12'h444, 32'h0000_7000, 32'h0000_0077);
    rd(2'd1, 32'h0000_6000, "R1 addr kept while disabled");
    rd(2'd0, ctlWord(12'h333, 16'h0020), "R1 count kept while disabled");

    tick();
    if (sb.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL scoreboard left %0d items, actual=%0d expected=0", sb.size(), sb.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule